// File: doc/BRIEF.md
# Ethernet Receive Frame Admission Check

This block sits at the front of an Ethernet receive path and decides, for each arriving frame, whether the frame may be taken in. The frame length arrives together with a one-cycle valid strobe. A set of static control bits is applied to that length: link state, receive enable, bus-master enable, long-frame enable and a bit that keeps bad frames. One cycle after the strobe, the block reports a verdict. A frame refused for length raises a one-cycle oversize pulse and advances a saturating oversize counter.

A separate combinational path decodes the receive buffer size in bytes. The inputs are a two-bit size code and an extension bit, and the result is a power of two. Any pairing that is not listed falls back to 2048 bytes. The packet datapath, DMA and CRC checking are all outside this block.

Top module: `rx_admit_check`

## Requirements
- R1: A frame can be accepted only if link_up, rx_en and bus_master_en are all 1 at the strobe. If any of them is 0, frm_accept is 0, and the frame neither pulses nor counts as oversize.
- R2: With long_pkt_en at 0 and keep_bad_pkts at 0, a length above 1522 is oversize. A length of exactly 1522 is accepted.
- R3: With keep_bad_pkts at 0, a length above 16384 is oversize whatever long_pkt_en is. With long_pkt_en at 1, a length of exactly 16384 is accepted.
- R4: With keep_bad_pkts at 1, no length is oversize, so a ready receiver accepts every frame.
- R5: An oversize frame at a ready receiver gives frm_accept 0 and oversize_pulse 1. In the same cycle oversize_cnt goes up by one.
- R6: oversize_cnt stops at its all-ones value and never wraps to zero.
- R7: dec_vld, frm_accept and oversize_pulse are registered. They show the verdict for a strobe one clock after the edge that samples it, and they are 0 in every cycle that follows no strobe. Strobes may arrive back to back.
- R8: With buf_ext at 1, size codes 01, 10 and 11 give buf_bytes of 16384, 8192 and 4096.
- R9: With buf_ext at 0, size codes 01, 10 and 11 give buf_bytes of 1024, 512 and 256.
- R10: Size code 00 gives 2048 whatever buf_ext is.
- R11: After reset, dec_vld, frm_accept and oversize_pulse are 0 and oversize_cnt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link is up |
| rx_en | input | 1 | Receiver enabled |
| bus_master_en | input | 1 | Bus mastering allowed |
| long_pkt_en | input | 1 | Raises the length limit to the jumbo limit |
| keep_bad_pkts | input | 1 | Turns off oversize dropping |
| frm_len_vld | input | 1 | Frame length strobe |
| frm_len | input | LEN_W | Frame length in bytes |
| buf_sel | input | 2 | Buffer size code |
| buf_ext | input | 1 | Buffer size extension bit |
| dec_vld | output | 1 | Verdict valid |
| frm_accept | output | 1 | Frame accepted |
| oversize_pulse | output | 1 | Frame dropped as oversize |
| oversize_cnt | output | CNT_W | Saturating oversize count |
| buf_bytes | output | BUF_W | Decoded buffer size in bytes |

## Verification
The bench probes each length limit exactly at its edge and one byte beyond it: 1522 against 1523, and 16384 against 16385. A design with an off-by-one comparison accepts or drops the wrong one of each pair. Oversize frames are sent while the receiver is not ready, to catch a counter that advances on frames it never judged. The bench drives the counter past its ceiling, where a wrapping counter falls back to zero. It also walks every buffer code with both extension values, so a missing fallback or swapped pair shows up as a wrong size.

// File: rtl/rx_admit_pkg.sv
package rx_admit_pkg;
  localparam int unsigned BUF_W = 15;
  typedef enum logic [1:0] {
    BSEL_DEF = 2'b00,
    BSEL_BIG = 2'b01,
    BSEL_MID = 2'b10,
    BSEL_SML = 2'b11
  } bufsel_e;
endpackage

// File: rtl/rx_ready_gate.sv
module rx_ready_gate (
  input  logic link_up,
  input  logic rx_en,
  input  logic bus_master_en,
  output logic rx_ready
);
  always_comb begin
    rx_ready = 1'b1;
    if (!link_up)       rx_ready = 1'b0;
    if (!rx_en)         rx_ready = 1'b0;
    if (!bus_master_en) rx_ready = 1'b0;
  end
endmodule

// File: rtl/rx_len_judge.sv
module rx_len_judge #(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned STD_MAX = 1522,
  parameter int unsigned JMB_MAX = 16384
) (
  input  logic [LEN_W-1:0] frm_len,
  input  logic             long_pkt_en,
  input  logic             keep_bad_pkts,
  output logic             too_long
);
  localparam logic [LEN_W-1:0] STD_LIM = LEN_W'(STD_MAX);
  localparam logic [LEN_W-1:0] JMB_LIM = LEN_W'(JMB_MAX);

  logic over_std;
  logic over_jmb;

  always_comb begin
    over_std = (frm_len > STD_LIM);
    over_jmb = (frm_len > JMB_LIM);
    if (keep_bad_pkts)
      too_long = 1'b0;
    else if (long_pkt_en)
      too_long = over_jmb;
    else
      too_long = over_std;
  end
endmodule

// File: rtl/rx_sat_counter.sv
module rx_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic [W-1:0] cnt_nxt;
  logic         cnt_ce;

  always_comb begin
    cnt_ce  = inc && (cnt != CMAX);
    cnt_nxt = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_ce) cnt <= cnt_nxt;
  end

  // R6: once full, the count stays full
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == CMAX) |-> (cnt == CMAX));
  // R5: the count only ever moves up by one
  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/rx_bufsize_dec.sv
module rx_bufsize_dec
  import rx_admit_pkg::*;
(
  input  logic [1:0]       buf_sel,
  input  logic             buf_ext,
  output logic [BUF_W-1:0] buf_bytes
);
  localparam int unsigned SH_DEF = 11;
  localparam int unsigned SH_LO  = 10;
  localparam int unsigned SH_HI  = 14;

  logic [3:0] shamt;
  bufsel_e    sel;

  always_comb begin
    sel = bufsel_e'(buf_sel);
    unique case (sel)
      BSEL_BIG: shamt = buf_ext ? 4'(SH_HI)     : 4'(SH_LO);
      BSEL_MID: shamt = buf_ext ? 4'(SH_HI - 1) : 4'(SH_LO - 1);
      BSEL_SML: shamt = buf_ext ? 4'(SH_HI - 2) : 4'(SH_LO - 2);
      default:  shamt = 4'(SH_DEF);
    endcase
    buf_bytes = BUF_W'(1) << shamt;
  end

  // R10: every decoded size is a single power of two
  always_comb begin
    p_pow2_r10: assert ($countones(buf_bytes) == 1 || $isunknown(buf_sel) || $isunknown(buf_ext));
  end
endmodule

// File: rtl/rx_admit_check.sv
module rx_admit_check
  import rx_admit_pkg::*;
#(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned STD_MAX = 1522,
  parameter int unsigned JMB_MAX = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_up,
  input  logic             rx_en,
  input  logic             bus_master_en,
  input  logic             long_pkt_en,
  input  logic             keep_bad_pkts,
  input  logic             frm_len_vld,
  input  logic [LEN_W-1:0] frm_len,
  input  logic [1:0]       buf_sel,
  input  logic             buf_ext,
  output logic             dec_vld,
  output logic             frm_accept,
  output logic             oversize_pulse,
  output logic [CNT_W-1:0] oversize_cnt,
  output logic [BUF_W-1:0] buf_bytes
);
  logic rst_m, rst_s;
  logic rx_ready, too_long;
  logic vld_nxt, acc_nxt, ovs_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  rx_ready_gate u_gate (
    .link_up       (link_up),
    .rx_en         (rx_en),
    .bus_master_en (bus_master_en),
    .rx_ready      (rx_ready)
  );

  rx_len_judge #(.LEN_W(LEN_W), .STD_MAX(STD_MAX), .JMB_MAX(JMB_MAX)) u_judge (
    .frm_len       (frm_len),
    .long_pkt_en   (long_pkt_en),
    .keep_bad_pkts (keep_bad_pkts),
    .too_long      (too_long)
  );

  always_comb begin
    vld_nxt = frm_len_vld;
    acc_nxt = frm_len_vld && rx_ready && !too_long;
    ovs_nxt = frm_len_vld && rx_ready && too_long;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      dec_vld        <= 1'b0;
      frm_accept     <= 1'b0;
      oversize_pulse <= 1'b0;
    end else begin
      dec_vld        <= vld_nxt;
      frm_accept     <= acc_nxt;
      oversize_pulse <= ovs_nxt;
    end
  end

  rx_sat_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_s),
    .inc   (ovs_nxt),
    .cnt   (oversize_cnt)
  );

  rx_bufsize_dec u_buf (
    .buf_sel   (buf_sel),
    .buf_ext   (buf_ext),
    .buf_bytes (buf_bytes)
  );

  // R1: acceptance requires a ready receiver at the strobe
  p_accept_ready_r1: assert property (@(posedge clk) disable iff (!rst_s)
    frm_accept |-> $past(link_up && rx_en && bus_master_en));
  // R2: without long frames, an accepted frame is within the standard limit
  p_std_limit_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (frm_accept && !$past(long_pkt_en) && !$past(keep_bad_pkts))
      |-> ($past(frm_len) <= LEN_W'(STD_MAX)));
  // R4: keeping bad frames suppresses oversize drops
  p_keep_bad_r4: assert property (@(posedge clk) disable iff (!rst_s)
    oversize_pulse |-> !$past(keep_bad_pkts));
  // R5: a drop and an accept never coincide, and a drop moves the count unless full
  p_drop_excl_r5: assert property (@(posedge clk) disable iff (!rst_s)
    !(oversize_pulse && frm_accept));
  p_drop_counts_r5: assert property (@(posedge clk) disable iff (!rst_s)
    oversize_pulse |-> ((oversize_cnt != $past(oversize_cnt)) || (&oversize_cnt)));
  // R7: a verdict appears exactly one clock after its strobe
  p_vld_follow_r7: assert property (@(posedge clk) disable iff (!rst_s)
    dec_vld == $past(frm_len_vld));
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_s)
    !dec_vld |-> (!frm_accept && !oversize_pulse));
endmodule

// File: tb/rx_admit_check_tb_top.sv
`timescale 1ns/1ps
module rx_admit_check_tb_top;
  localparam int LEN_W = 16;
  localparam int CNT_W = 4;
  localparam int CMAX  = 15;

  logic clk = 1'b0;
  logic rst_n;
  logic link_up, rx_en, bus_master_en, long_pkt_en, keep_bad_pkts;
  logic frm_len_vld;
  logic [LEN_W-1:0] frm_len;
  logic [1:0] buf_sel;
  logic buf_ext;
  logic dec_vld, frm_accept, oversize_pulse;
  logic [CNT_W-1:0] oversize_cnt;
  logic [14:0] buf_bytes;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit mon_on = 0;
  string cur_req = "R11";

  // reference model state
  int  m_vld, m_acc, m_ovs, m_cnt;

  always #2.5 clk = ~clk;

  rx_admit_check #(.LEN_W(LEN_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .rx_en(rx_en),
    .bus_master_en(bus_master_en), .long_pkt_en(long_pkt_en),
    .keep_bad_pkts(keep_bad_pkts), .frm_len_vld(frm_len_vld),
    .frm_len(frm_len), .buf_sel(buf_sel), .buf_ext(buf_ext),
    .dec_vld(dec_vld), .frm_accept(frm_accept),
    .oversize_pulse(oversize_pulse), .oversize_cnt(oversize_cnt),
    .buf_bytes(buf_bytes)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural model, evaluated at every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld = 0; m_acc = 0; m_ovs = 0; m_cnt = 0;
    end else begin
      int  len;
      bit  rdy, ovr;
      len = int'(frm_len);
      rdy = link_up && rx_en && bus_master_en;
      ovr = 0;
      if (!keep_bad_pkts) begin
        if (len > 16384) ovr = 1;
        if (!long_pkt_en && len > 1522) ovr = 1;
      end
      m_vld = frm_len_vld ? 1 : 0;
      m_acc = (frm_len_vld && rdy && !ovr) ? 1 : 0;
      m_ovs = (frm_len_vld && rdy && ovr) ? 1 : 0;
      if (m_ovs == 1 && m_cnt < CMAX) m_cnt++;
    end
  end

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (mon_on) begin
      chk(cur_req, "dec_vld", int'(dec_vld), m_vld);
      chk(cur_req, "frm_accept", int'(frm_accept), m_acc);
      chk(cur_req, "oversize_pulse", int'(oversize_pulse), m_ovs);
      chk(cur_req, "oversize_cnt", int'(oversize_cnt), m_cnt);
    end
  end

  task automatic send(input int len);
    frm_len_vld = 1'b1;
    frm_len = LEN_W'(len);
    @(negedge clk);
    frm_len_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_ctl(input bit l, input bit r, input bit b, input bit lpe, input bit kb);
    link_up = l; rx_en = r; bus_master_en = b; long_pkt_en = lpe; keep_bad_pkts = kb;
  endtask

  task automatic chk_buf(input string req, input int sel, input bit ext, input int exp);
    buf_sel = 2'(sel); buf_ext = ext;
    #1;
    chk(req, "buf_bytes", int'(buf_bytes), exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    set_ctl(1, 1, 1, 0, 0);
    frm_len_vld = 1'b0; frm_len = '0; buf_sel = 2'b00; buf_ext = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset values
    chk("R11", "dec_vld", int'(dec_vld), 0);
    chk("R11", "frm_accept", int'(frm_accept), 0);
    chk("R11", "oversize_pulse", int'(oversize_pulse), 0);
    chk("R11", "oversize_cnt", int'(oversize_cnt), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1;

    // R1: every readiness combination
    cur_req = "R1";
    for (int k = 0; k < 8; k++) begin
      set_ctl(k[0], k[1], k[2], 0, 0);
      send(100);
      send(3000);   // R1: oversize while not ready must not count
    end
    set_ctl(1, 1, 1, 0, 0);

    // R2: standard limit edge
    cur_req = "R2";
    send(64); send(1522); send(1523); send(3000);

    // R3: jumbo limit edge
    cur_req = "R3";
    set_ctl(1, 1, 1, 1, 0);
    send(1523); send(16384); send(16385); send(65535);
    set_ctl(1, 1, 1, 0, 0);
    send(16385);

    // R4: keep bad frames
    cur_req = "R4";
    set_ctl(1, 1, 1, 0, 1);
    send(2000); send(40000);
    set_ctl(1, 1, 1, 1, 1);
    send(20000);

    // R7: back-to-back strobes
    cur_req = "R7";
    set_ctl(1, 1, 1, 0, 0);
    frm_len_vld = 1'b1;
    frm_len = 16'd500;  @(negedge clk);
    frm_len = 16'd1600; @(negedge clk);
    frm_len = 16'd1522; @(negedge clk);
    frm_len_vld = 1'b0;
    repeat (2) @(negedge clk);

    // R5 and R6: drive the counter past its ceiling
    cur_req = "R6";
    for (int k = 0; k < 20; k++) send(5000);
    chk("R6", "oversize_cnt saturated", int'(oversize_cnt), CMAX);
    cur_req = "R5";
    send(9000);
    chk("R5", "oversize_cnt held", int'(oversize_cnt), CMAX);

    // R8, R9, R10: buffer size decode
    chk_buf("R10", 0, 0, 2048);
    chk_buf("R10", 0, 1, 2048);
    chk_buf("R9", 1, 0, 1024);
    chk_buf("R9", 2, 0, 512);
    chk_buf("R9", 3, 0, 256);
    chk_buf("R8", 1, 1, 16384);
    chk_buf("R8", 2, 1, 8192);
    chk_buf("R8", 3, 1, 4096);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule